// File: doc/BRIEF.md
# Stuck Bus Timeout and Recovery Clocker

This block sits beside the card-side port of a two-wire bus buffer. It watches the already synchronized card-side data and clock line levels. A stuck-low watchdog runs whenever either line is low and is cleared only while both lines read high. When the watchdog expires, the block raises a fault. The buffer uses that fault to open the connection between backplane and card. The fault also turns off the rise-time accelerators.

After a fault, a guard interval must pass before anything is driven. The block then issues a bounded burst of recovery clocks on the card clock line through an open-drain pull-down request. Each pulse pulls the line low for half a period and then releases it, so that the line can rise. The burst ends early as soon as both lines read high while the pull-down is released. An enable input stops all clocking while it is low, and its rising edge clears a pending fault. A supply-good input holds the block in lockout while it is low.

All intervals are parameters in microseconds or hertz. Cycle counts are derived from them using the system clock frequency.

Top module: `stuck_bus_recovery`

## Requirements
- R1: Line levels are 1 = high. The watchdog counts every cycle in which `sda_i` or `scl_i` reads 0, and any single cycle with both lines at 1 clears it. `fault_o` rises exactly TIMEOUT_CYC clock edges after the first edge that samples a continuous low, where TIMEOUT_CYC = CLK_FREQ_HZ/1000*TIMEOUT_US/1000.
- R2: `fault_o` = 1 means the bus is stuck. `accel_en_o` is 1 only when `pwr_good_i` = 1 and `fault_o` = 0.
- R3: The first recovery pulse (`scl_pull_o` = 1 means pull card SCL low) starts exactly GUARD_CYC edges after `fault_o` rises, where GUARD_CYC = ceil(CLK_FREQ_HZ/1000*GUARD_US/1000).
- R4: A burst has at most MAX_PULSES pulses. Each pulse holds `scl_pull_o` = 1 for HALF_CYC = CLK_FREQ_HZ/(2*RECOV_HZ) cycles and then 0 for HALF_CYC cycles.
- R5: If both lines read 1 while a fault is set and `scl_pull_o` = 0, then at the next edge `fault_o` clears and no further pulse follows.
- R6: While `en_i` = 0, no pulse is issued. A running burst releases `scl_pull_o` at the first edge that samples `en_i` = 0, and the fault stays set.
- R7: A rising edge on `en_i` while a fault is set clears the fault at that edge. It also restarts the watchdog from zero, and the watchdog keeps running.
- R8: While `pwr_good_i` = 0, the fault, the watchdog and the burst are all cleared. When the bus is stuck at power-up, `fault_o` rises TIMEOUT_CYC edges after the first edge that samples `pwr_good_i` = 1.
- R9: `busy_o` is 1 from the fault edge until the end of the last high phase of the burst.
- R10: After a complete burst, `fault_o` stays at 1 until the lines free or `en_i` rises.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sda_i | input | 1 | Synchronized card-side data level |
| scl_i | input | 1 | Synchronized card-side clock level |
| en_i | input | 1 | Connection enable; a rising edge clears a fault |
| pwr_good_i | input | 1 | Supply good; low holds lockout |
| fault_o | output | 1 | Stuck-bus fault, opens the connection |
| scl_pull_o | output | 1 | Request to pull card SCL low |
| busy_o | output | 1 | Guard or recovery burst in progress |
| accel_en_o | output | 1 | Rise-time accelerator permission |

## Verification
The hardest situation to reach is a stuck device that releases data partway through a burst. It has to let go during a released half of the clock, after a chosen number of pulses. The bench models the card lines as wired-AND, with its own stuck device plus the block's pull-down. It counts pull-down pulses on the fly and lets the device release data in the first released cycle after a randomly chosen pulse count. This exercises the early stop at many positions. Disabling during a low phase and losing power during a fault are driven directly from the same line model.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic [2:0] {
    RC_IDLE,
    RC_GUARD,
    RC_LOW,
    RC_HIGH,
    RC_HOLD
  } rc_state_e;

  function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/sbr_stuck_timer.sv
module sbr_stuck_timer #(
  parameter int unsigned LIMIT = 1500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q;

  assign expire_o = run_i && !clr_i && (cnt_q == W'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_i || !run_i || expire_o) cnt_q <= '0;
    else cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/sbr_clocker.sv
module sbr_clocker
  import sbr_pkg::*;
#(
  parameter int unsigned GUARD_CYC  = 2000,
  parameter int unsigned HALF_CYC   = 2941,
  parameter int unsigned MAX_PULSES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic start_i,
  input  logic en_i,
  output logic pull_o,
  output logic busy_o
);
  localparam int unsigned SPAN = (GUARD_CYC > HALF_CYC) ? GUARD_CYC : HALF_CYC;
  localparam int unsigned CW   = $clog2(SPAN + 1);
  localparam int unsigned PW   = $clog2(MAX_PULSES + 1);

  rc_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] npulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= RC_IDLE;
      cnt_q    <= '0;
      npulse_q <= '0;
    end else if (clear_i) begin
      state_q  <= RC_IDLE;
      cnt_q    <= '0;
      npulse_q <= '0;
    end else begin
      unique case (state_q)
        RC_IDLE: begin
          cnt_q    <= '0;
          npulse_q <= '0;
          if (start_i) state_q <= en_i ? RC_GUARD : RC_HOLD;
        end
        RC_GUARD: begin
          if (!en_i) state_q <= RC_HOLD;
          else if (cnt_q == CW'(GUARD_CYC - 1)) begin
            state_q <= RC_LOW;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + CW'(1);
        end
        RC_LOW: begin
          if (!en_i) state_q <= RC_HOLD;
          else if (cnt_q == CW'(HALF_CYC - 1)) begin
            state_q <= RC_HIGH;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + CW'(1);
        end
        RC_HIGH: begin
          if (!en_i) state_q <= RC_HOLD;
          else if (cnt_q == CW'(HALF_CYC - 1)) begin
            cnt_q    <= '0;
            npulse_q <= npulse_q + PW'(1);
            state_q  <= (npulse_q == PW'(MAX_PULSES - 1)) ? RC_HOLD : RC_LOW;
          end else cnt_q <= cnt_q + CW'(1);
        end
        default: state_q <= RC_HOLD;
      endcase
    end
  end

  assign pull_o = (state_q == RC_LOW);
  assign busy_o = (state_q == RC_GUARD) || (state_q == RC_LOW) || (state_q == RC_HIGH);
endmodule

// File: rtl/stuck_bus_recovery.sv
module stuck_bus_recovery #(
  parameter int unsigned CLK_FREQ_HZ = 50000000,
  parameter int unsigned TIMEOUT_US  = 30000,
  parameter int unsigned GUARD_US    = 40,
  parameter int unsigned RECOV_HZ    = 8500,
  parameter int unsigned MAX_PULSES  = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sda_i,
  input  logic scl_i,
  input  logic en_i,
  input  logic pwr_good_i,
  output logic fault_o,
  output logic scl_pull_o,
  output logic busy_o,
  output logic accel_en_o
);
  localparam int unsigned CLK_KHZ     = CLK_FREQ_HZ / 1000;
  localparam int unsigned TIMEOUT_CYC = CLK_KHZ * TIMEOUT_US / 1000;
  localparam int unsigned GUARD_CYC   = sbr_pkg::ceil_div(CLK_KHZ * GUARD_US, 1000);
  localparam int unsigned HALF_CYC    = CLK_FREQ_HZ / (2 * RECOV_HZ);

  logic bus_free, en_q, en_rise, expire, fault_q, fault_clear, pull, busy;

  assign bus_free    = sda_i && scl_i;
  assign en_rise     = en_i && !en_q;
  // released-phase high on both lines, or re-enable, ends the fault
  assign fault_clear = fault_q && (en_rise || (bus_free && !pull));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      en_q <= en_i;
      if (!pwr_good_i) fault_q <= 1'b0;
      else if (expire) fault_q <= 1'b1;
      else if (fault_clear) fault_q <= 1'b0;
    end
  end

  sbr_stuck_timer #(.LIMIT(TIMEOUT_CYC)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!pwr_good_i || fault_q),
    .run_i   (!bus_free),
    .expire_o(expire)
  );

  sbr_clocker #(
    .GUARD_CYC (GUARD_CYC),
    .HALF_CYC  (HALF_CYC),
    .MAX_PULSES(MAX_PULSES)
  ) i_clocker (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(!pwr_good_i || fault_clear),
    .start_i(expire),
    .en_i   (en_i),
    .pull_o (pull),
    .busy_o (busy)
  );

  assign fault_o    = fault_q;
  assign scl_pull_o = pull;
  assign busy_o     = busy;
  assign accel_en_o = pwr_good_i && !fault_q;
endmodule

// File: rtl/stuck_bus_recovery_chk.sv
module stuck_bus_recovery_chk #(
  parameter int unsigned MAX_PULSES = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sda_i,
  input logic scl_i,
  input logic en_i,
  input logic pwr_good_i,
  input logic fault_o,
  input logic scl_pull_o,
  input logic busy_o,
  input logic accel_en_o
);
  localparam int unsigned PW = $clog2(MAX_PULSES + 2);
  logic [PW-1:0] seen_q;
  logic          pull_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
      pull_q <= 1'b0;
    end else begin
      pull_q <= scl_pull_o;
      if (!fault_o) seen_q <= '0;
      else if (scl_pull_o && !pull_q && seen_q <= PW'(MAX_PULSES)) seen_q <= seen_q + PW'(1);
    end
  end

  p_fault_needs_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past(!(sda_i && scl_i)));
  p_accel_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !accel_en_o);
  p_pull_in_fault_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_pull_o |-> fault_o);
  p_burst_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q <= PW'(MAX_PULSES));
  p_free_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !scl_pull_o && sda_i && scl_i) |=> (!fault_o && !scl_pull_o));
  p_no_clock_disabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !scl_pull_o);
  p_en_rise_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && en_i && !$past(en_i) && pwr_good_i) |=> !fault_o);
  p_lockout_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> (!fault_o && !busy_o && !scl_pull_o));
  p_busy_accel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !accel_en_o);
endmodule

bind stuck_bus_recovery stuck_bus_recovery_chk #(.MAX_PULSES(MAX_PULSES)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sda_i(sda_i), .scl_i(scl_i), .en_i(en_i),
  .pwr_good_i(pwr_good_i), .fault_o(fault_o), .scl_pull_o(scl_pull_o),
  .busy_o(busy_o), .accel_en_o(accel_en_o)
);

// File: tb/test_stuck_bus_recovery.sv
module test_stuck_bus_recovery;
  localparam int CLK_PERIOD = 10;
  localparam int F_HZ = 1000000, T_US = 300, G_US = 40, R_HZ = 25000, MAXP = 16;
  localparam int TO   = (F_HZ / 1000) * T_US / 1000;
  localparam int GC   = ((F_HZ / 1000) * G_US + 999) / 1000;
  localparam int HALF = F_HZ / (2 * R_HZ);

  logic clk = 0, rst_ni = 0, en = 1, pwr = 1;
  logic dev_sda_low = 0, dev_scl_low = 0;
  logic fault, pull, busy, accel, sda, scl;
  int   errors = 0, checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign sda = !dev_sda_low;
  assign scl = !dev_scl_low && !pull;

  stuck_bus_recovery #(
    .CLK_FREQ_HZ(F_HZ), .TIMEOUT_US(T_US), .GUARD_US(G_US),
    .RECOV_HZ(R_HZ), .MAX_PULSES(MAXP)
  ) i_stuck_bus_recovery (
    .clk_i(clk), .rst_ni(rst_ni), .sda_i(sda), .scl_i(scl), .en_i(en),
    .pwr_good_i(pwr), .fault_o(fault), .scl_pull_o(pull), .busy_o(busy),
    .accel_en_o(accel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_accel(input bit p, input bit f);
    return int'(p && !f);
  endfunction

  // starts at the negedge where fault is first visible
  task automatic run_burst(input int rel_after, output int pulses, output int bad_len,
                           output int guard);
    int lo = 0, hi = 0;
    bit prev = 0;
    pulses = 0; bad_len = 0; guard = -1;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (pull) begin
        lo++;
        if (!prev) begin
          if (guard < 0) guard = c + 1;
          if (pulses > 0 && hi != HALF) bad_len++;
          pulses++;
          hi = 0;
        end
      end else begin
        if (prev) begin
          if (lo != HALF) bad_len++;
          lo = 0;
        end
        if (pulses > 0) hi++;
      end
      prev = pull;
      if (!fault) break;
      if (!busy && pulses > 0) break;
      if (rel_after > 0 && pulses == rel_after && !pull && dev_sda_low) dev_sda_low = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int p, b, g, n;
    void'($urandom(32'h5eed_0303));
    step(3);
    rst_ni = 1;
    step(2);
    chk(fault == 0 && pull == 0 && busy == 0, "R2 reset state", int'(fault), 0);
    chk(accel == 1'(exp_accel(pwr, fault)), "R2 accel after reset", int'(accel), 1);

    // R1: random short lows never time out
    for (int t = 0; t < 20; t++) begin
      n = $urandom_range(TO - 1, 1);
      if ($urandom_range(1, 0) == 1) dev_sda_low = 1; else dev_scl_low = 1;
      step(n);
      dev_sda_low = 0; dev_scl_low = 0;
      step($urandom_range(3, 1));
      chk(fault == 0, "R1 low shorter than timeout", int'(fault), 0);
    end

    // R1 exact timeout, R2, R3, R4, R9, R10
    dev_sda_low = 1;
    step(TO - 1);
    chk(fault == 0, "R1 one edge before timeout", int'(fault), 0);
    step(1);
    chk(fault == 1, "R1 timeout edge", int'(fault), 1);
    chk(accel == 0, "R2 accel off at fault", int'(accel), 0);
    chk(busy == 1, "R9 busy at fault", int'(busy), 1);
    run_burst(0, p, b, g);
    chk(g == GC, "R3 guard delay", g, GC);
    chk(p == MAXP, "R4 pulse count", p, MAXP);
    chk(b == 0, "R4 phase lengths", b, 0);
    chk(busy == 0, "R9 busy ends after burst", int'(busy), 0);
    step(30);
    chk(fault == 1 && pull == 0, "R10 fault held after burst", int'(fault), 1);
    dev_sda_low = 0;
    step(1);
    chk(fault == 0, "R5 free clears held fault", int'(fault), 0);

    // R5 early stop at random pulse counts
    for (int t = 0; t < 6; t++) begin
      n = $urandom_range(MAXP - 1, 1);
      dev_scl_low = ($urandom_range(1, 0) == 1);
      dev_sda_low = 1;
      step(TO);
      dev_scl_low = 0;
      chk(fault == 1, "R1 timeout random trial", int'(fault), 1);
      run_burst(n, p, b, g);
      chk(p == n && fault == 0, "R5 early stop pulses", p, n);
      step(5);
      chk(pull == 0 && fault == 0 && accel == 1, "R5 no pulse after stop", int'(pull), 0);
    end

    // R6 disable in a low phase, then R7 re-enable
    dev_sda_low = 1;
    step(TO + GC + 3);
    chk(pull == 1, "R6 in low phase", int'(pull), 1);
    en = 0;
    step(1);
    chk(pull == 0, "R6 pull released on disable", int'(pull), 0);
    n = 0;
    for (int c = 0; c < 200; c++) begin
      step(1);
      if (pull) n++;
    end
    chk(n == 0 && fault == 1, "R6 no pulses while disabled", n, 0);
    en = 1;
    step(1);
    chk(fault == 0, "R7 enable edge clears fault", int'(fault), 0);
    step(TO - 1);
    chk(fault == 0, "R7 timer restarted from zero", int'(fault), 0);
    step(1);
    chk(fault == 1, "R7 timer still running", int'(fault), 1);

    // R8 lockout and power-up into stuck bus
    pwr = 0;
    step(1);
    chk(fault == 0 && busy == 0 && pull == 0, "R8 lockout clears", int'(fault), 0);
    chk(accel == 1'(exp_accel(pwr, fault)), "R8 accel in lockout", int'(accel), 0);
    step(TO + 20);
    chk(fault == 0, "R8 no fault during lockout", int'(fault), 0);
    pwr = 1;
    step(TO - 1);
    chk(fault == 0, "R8 before timeout after power", int'(fault), 0);
    step(1);
    chk(fault == 1, "R8 timeout after power", int'(fault), 1);

    // R6 fault while disabled: no guard, no pulses
    dev_sda_low = 0;
    step(2);
    en = 0;
    dev_sda_low = 1;
    step(TO);
    chk(fault == 1, "R6 fault while disabled", int'(fault), 1);
    n = 0;
    for (int c = 0; c < GC + 4 * HALF; c++) begin
      step(1);
      if (pull || busy) n++;
    end
    chk(n == 0, "R6 no burst while disabled", n, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule